// File: doc/BRIEF.md
# Pulse Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It takes a fast clock from the oscillator side and emits one comparison pulse for every P×N+A of its cycles. The ratio is built the usual way for a dual-modulus scheme. A prescaler stage, modelled here in logic, divides by P+1 while a swallow count is still pending and by P afterwards. A main programmable counter counts the prescaler outputs and closes the cycle after N of them.

The lower modulus P comes from two controls. A family input picks the small family (8/9 or 16/17) or the large family (64/65 or 128/129), and a select bit picks the pair within that family. The swallow value A and the main value N are sampled together with the modulus controls only at the boundary of a division cycle. A cycle that is under way therefore always completes with the settings it started with. An enable input holds the whole divider in its load state, and no pulses are produced while it is low.

Top module: `pulse_swallow_div`

## Requirements
- R1: With settings held constant, successive output pulses are exactly P×N+A input clocks apart, where P is the lower prescaler modulus.
- R2: Modulus encoding: with `fam_large`=0, `mod_sel`=1 gives P=8 and `mod_sel`=0 gives P=16. With `fam_large`=1, `mod_sel`=1 gives P=64 and `mod_sel`=0 gives P=128.
- R3: A swallow value of 0 gives a period of exactly P×N, and A covers the full range 0 to 127 (7 bits).
- R4: The largest legal swallow value A=N−1 gives a period of P×N+N−1. The block requires A<N.
- R5: N is 11 bits wide. The smallest legal value N=3 and the largest value 2047 both divide correctly. Values below 3 are not supported.
- R6: Each output pulse is high for exactly one input clock.
- R7: A, N, `fam_large` and `mod_sel` changed in the middle of a cycle do not alter that cycle. They take effect from the following cycle.
- R8: While `en` is low, no pulse is produced and the divider stays in its load state. The first pulse after `en` rises comes P×N+A clocks later, counting the first rising edge with `en` high as clock 1.
- R9: After the asynchronous reset (`rst_n` low), `cmp_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast oscillator-side clock being divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds the divider in its load state |
| fam_large | input | 1 | Prescaler family: 0 small (8/9, 16/17), 1 large (64/65, 128/129) |
| mod_sel | input | 1 | Pair select within the family: 1 lower pair, 0 upper pair |
| swallow_a | input | A_W (7) | Swallow count A, 0..127, must be below N |
| main_n | input | N_W (11) | Main count N, 3..2047 |
| cmp_pulse | output | 1 | One-clock pulse marking the end of each division cycle |

## Verification
The bench measures the first-pulse latency and the next pulse interval for each modulus pair. It covers the corners A=0, A=N−1, N=3 and the 2047/127 maximum, along with seeded random settings. A design that applies P+1 for one prescaler period too many or too few would be off by exactly one clock per mistake. A design that swaps the select encoding would give a period off by a factor of two. A design that latches settings mid-cycle would show a first period that matches neither setting, and a stretched or doubled pulse would show up in the one-clock-later sample. The bench also holds `en` low and watches for stray pulses.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

   // Lower modulus for a family/select pair, given the log2 of each family's base.
   function automatic int unsigned lower_modulus(input logic fam_large,
                                                 input logic mod_sel,
                                                 input int unsigned small_log2,
                                                 input int unsigned large_log2);
      int unsigned base_log2;
      base_log2 = fam_large ? large_log2 : small_log2;
      if (!mod_sel) base_log2 = base_log2 + 1;
      return 32'd1 << base_log2;
   endfunction

   typedef struct packed {
      logic fam_large;
      logic mod_sel;
   } pswd_mode_t;

endpackage

// File: rtl/pswd_prescaler.sv
module pswd_prescaler #(
   parameter int unsigned SMALL_LOG2 = 3,
   parameter int unsigned LARGE_LOG2 = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  pswd_pkg::pswd_mode_t mode,
   input  logic               plus_one,
   output logic               tick
);
   import pswd_pkg::*;

   localparam int unsigned PC_W = LARGE_LOG2 + 2;
   localparam logic [PC_W-1:0] P_S_LO = PC_W'(lower_modulus(1'b0, 1'b1, SMALL_LOG2, LARGE_LOG2));
   localparam logic [PC_W-1:0] P_S_HI = PC_W'(lower_modulus(1'b0, 1'b0, SMALL_LOG2, LARGE_LOG2));
   localparam logic [PC_W-1:0] P_L_LO = PC_W'(lower_modulus(1'b1, 1'b1, SMALL_LOG2, LARGE_LOG2));
   localparam logic [PC_W-1:0] P_L_HI = PC_W'(lower_modulus(1'b1, 1'b0, SMALL_LOG2, LARGE_LOG2));

   logic [PC_W-1:0] p_val;
   logic [PC_W-1:0] lim;
   logic [PC_W-1:0] pc;

   always_comb begin
      unique case ({mode.fam_large, mode.mod_sel})
         2'b01:   p_val = P_S_LO;
         2'b00:   p_val = P_S_HI;
         2'b11:   p_val = P_L_LO;
         default: p_val = P_L_HI;
      endcase
      // Terminal value of the count: P-1 normally, P while swallowing.
      lim = p_val - PC_W'(1) + PC_W'(plus_one);
   end

   assign tick = (pc == lim) && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pc <= '0;
      else if (clr || tick) pc <= '0;
      else                 pc <= pc + PC_W'(1);
   end

   // R1: the prescaler count never runs past the terminal value of the current modulus
   assert_pc_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pc <= lim);

endmodule

// File: rtl/pswd_counters.sv
module pswd_counters #(
   parameter int unsigned A_W = 7,
   parameter int unsigned N_W = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic           tick,
   input  logic [A_W-1:0] a_in,
   input  logic [N_W-1:0] n_in,
   output logic           hold,
   output logic           load,
   output logic           plus_one,
   output logic           cyc_end
);
   logic [A_W-1:0] a_cnt;
   logic [N_W-1:0] n_cnt;
   logic           primed;

   assign hold     = !en || !primed;
   assign cyc_end  = tick && (n_cnt == N_W'(1)) && !hold;
   assign load     = hold || cyc_end;
   assign plus_one = (a_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_cnt  <= '0;
         n_cnt  <= '0;
         primed <= 1'b0;
      end else if (load) begin
         a_cnt  <= a_in;
         n_cnt  <= n_in;
         primed <= 1'b1;
      end else if (tick) begin
         n_cnt <= n_cnt - N_W'(1);
         if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
      end
   end

   // R4: with legal settings (A < N), the swallow count stays below the main count
   assert_swallow_below_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |-> (N_W'(a_cnt) < n_cnt));

   // R5: a running main count never reaches zero before the cycle closes
   assert_main_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |-> (n_cnt != '0));

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
   parameter int unsigned A_W        = 7,
   parameter int unsigned N_W        = 11,
   parameter int unsigned SMALL_LOG2 = 3,
   parameter int unsigned LARGE_LOG2 = 6,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic           clk_vco,
   input  logic           rst_n,
   input  logic           en,
   input  logic           fam_large,
   input  logic           mod_sel,
   input  logic [A_W-1:0] swallow_a,
   input  logic [N_W-1:0] main_n,
   output logic           cmp_pulse
);
   import pswd_pkg::*;

   if (A_W < 1 || A_W >= N_W) begin : g_bad_widths
      $error("pulse_swallow_div: A_W must be at least 1 and below N_W");
   end
   if (SMALL_LOG2 < 1 || LARGE_LOG2 <= SMALL_LOG2) begin : g_bad_moduli
      $error("pulse_swallow_div: LARGE_LOG2 must exceed SMALL_LOG2 >= 1");
   end

   pswd_mode_t mode_q;
   logic       tick;
   logic       hold;
   logic       load;
   logic       plus_one;
   logic       cyc_end;

   always_ff @(posedge clk_vco or negedge rst_n) begin
      if (!rst_n)    mode_q <= '0;
      else if (load) mode_q <= '{fam_large: fam_large, mod_sel: mod_sel};
   end

   pswd_prescaler #(
      .SMALL_LOG2 (SMALL_LOG2),
      .LARGE_LOG2 (LARGE_LOG2)
   ) u_presc (
      .clk      (clk_vco),
      .rst_n    (rst_n),
      .clr      (hold),
      .mode     (mode_q),
      .plus_one (plus_one),
      .tick     (tick)
   );

   pswd_counters #(
      .A_W (A_W),
      .N_W (N_W)
   ) u_cnt (
      .clk      (clk_vco),
      .rst_n    (rst_n),
      .en       (en),
      .tick     (tick),
      .a_in     (swallow_a),
      .n_in     (main_n),
      .hold     (hold),
      .load     (load),
      .plus_one (plus_one),
      .cyc_end  (cyc_end)
   );

   if (OUT_REG) begin : g_out_reg
      logic pulse_q;
      always_ff @(posedge clk_vco or negedge rst_n) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= cyc_end;
      end
      assign cmp_pulse = pulse_q;
   end else begin : g_out_comb
      assign cmp_pulse = cyc_end;
   end

   // R6: the comparison pulse lasts a single clock
   assert_pulse_single_R6: assert property (@(posedge clk_vco) disable iff (!rst_n)
      cmp_pulse |=> !cmp_pulse);

   // R8: no pulse follows a clock on which the divider was disabled
   assert_idle_quiet_R8: assert property (@(posedge clk_vco) disable iff (!rst_n)
      !en |=> !cmp_pulse);

   // R7: the latched modulus choice only moves at a cycle boundary or while held
   assert_mode_steady_R7: assert property (@(posedge clk_vco) disable iff (!rst_n)
      !load |=> $stable(mode_q));

endmodule

// File: tb/pulse_swallow_div_tb.sv
module pulse_swallow_div_tb;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 195000;

   logic        clk_vco = 1'b0;
   logic        rst_n   = 1'b0;
   logic        en      = 1'b0;
   logic        fam_large = 1'b0;
   logic        mod_sel   = 1'b1;
   logic [6:0]  swallow_a = '0;
   logic [10:0] main_n    = 11'd3;
   logic        cmp_pulse;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk_vco = ~clk_vco;

   pulse_swallow_div u_dut (
      .clk_vco   (clk_vco),
      .rst_n     (rst_n),
      .en        (en),
      .fam_large (fam_large),
      .mod_sel   (mod_sel),
      .swallow_a (swallow_a),
      .main_n    (main_n),
      .cmp_pulse (cmp_pulse)
   );

   function automatic int exp_period(input bit fam, input bit sel, input int a, input int n);
      int p;
      p = fam ? (sel ? 64 : 128) : (sel ? 8 : 16);
      return p * n + a;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Counts rising edges (starting from 'start') until the pulse is seen at a falling edge.
   task automatic wait_pulse(input int start, input int limit, output int cyc);
      cyc = start;
      do begin
         @(posedge clk_vco);
         cyc++;
         @(negedge clk_vco);
      end while (!cmp_pulse && cyc < limit);
   endtask

   task automatic setup(input bit fam, input bit sel, input int a, input int n);
      @(negedge clk_vco);
      en        = 1'b0;
      fam_large = fam;
      mod_sel   = sel;
      swallow_a = 7'(a);
      main_n    = 11'(n);
      repeat (3) begin
         @(negedge clk_vco);
         check("R8 idle", int'(cmp_pulse), 0);
      end
   endtask

   task automatic run_case(input string req, input bit fam, input bit sel, input int a, input int n);
      int t;
      int cyc;
      t = exp_period(fam, sel, a, n);
      setup(fam, sel, a, n);
      en = 1'b1;
      wait_pulse(0, t + 20, cyc);
      check({req, " R8 first pulse latency"}, cyc, t);
      @(posedge clk_vco);
      @(negedge clk_vco);
      check("R6 width", int'(cmp_pulse), 0);
      wait_pulse(1, t + 20, cyc);
      check({req, " R1 period"}, cyc, t);
   endtask

   initial begin
      int cyc;
      int t1;
      int t2;
      void'($urandom(32'd20240611));
      repeat (2) @(negedge clk_vco);
      check("R9 reset", int'(cmp_pulse), 0);
      rst_n = 1'b1;

      // R2: each modulus pair, R5: minimum N, R3: A=0
      run_case("R2 R5 R3 small-lo", 1'b0, 1'b1, 0, 3);
      run_case("R2 R4 small-lo", 1'b0, 1'b1, 2, 3);
      run_case("R2 R4 small-hi", 1'b0, 1'b0, 9, 10);
      run_case("R2 R4 large-lo", 1'b1, 1'b1, 4, 5);
      run_case("R2 R3 large-hi", 1'b1, 1'b0, 0, 3);
      run_case("R5 R3 max N and A", 1'b0, 1'b1, 127, 2047);
      run_case("R4 large-hi A=N-1", 1'b1, 1'b0, 63, 64);

      // seeded random settings
      for (int i = 0; i < 6; i++) begin
         int n;
         int a;
         bit f;
         bit s;
         n = 3 + int'($urandom % 38);
         a = int'($urandom % n);
         f = 1'($urandom);
         s = 1'($urandom);
         run_case("R1 random", f, s, a, n);
      end

      // R7: settings changed mid-cycle apply from the next cycle only
      t1 = exp_period(1'b0, 1'b1, 1, 5);
      t2 = exp_period(1'b0, 1'b0, 6, 7);
      setup(1'b0, 1'b1, 1, 5);
      en = 1'b1;
      repeat (10) begin
         @(posedge clk_vco);
         @(negedge clk_vco);
      end
      fam_large = 1'b0;
      mod_sel   = 1'b0;
      swallow_a = 7'd6;
      main_n    = 11'd7;
      wait_pulse(10, t1 + 20, cyc);
      check("R7 current cycle keeps old settings", cyc, t1);
      wait_pulse(0, t2 + 20, cyc);
      check("R7 next cycle uses new settings", cyc, t2);

      // R8: dropping enable stops pulses
      @(negedge clk_vco);
      en = 1'b0;
      repeat (t2 + 5) begin
         @(negedge clk_vco);
         if (cmp_pulse) check("R8 pulse while disabled", 1, 0);
      end
      check("R8 quiet while disabled", int'(cmp_pulse), 0);

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk_vco);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule